// File: doc/BRIEF.md
# I2C Target with Address-Match Clock Stretching

This block is the target (slave) end of a two-wire I2C bus. Both bus lines pass through a two-flop synchroniser. The block then watches for start and stop conditions and shifts in the first byte after every start. It compares the upper seven bits of that byte with the `own_addr` input. On a match, hardware acknowledges on the ninth clock. After that clock falls, the block holds SCL low and pulses `addr_irq`. On a mismatch it leaves SDA high, raises no interrupt and does not hold the clock. It then ignores the bus until the next start or repeated start.

Data moves over two valid/ready streams. In a read transaction the master clocks bytes out of the block. The block keeps SCL low with `tx_ready` high until the transmit stream presents a byte. A handshake (`tx_valid && tx_ready`) loads that byte and releases the clock. The byte goes out MSB first. After each byte the block samples the master's acknowledge. An ACK makes it stretch again for the next byte. A NACK makes it release SDA until the next start.

In a write transaction each received byte is acknowledged and presented on `rx_data`/`rx_valid`. The byte stays there unchanged until `rx_ready` takes it. While a byte is still pending, or while `rx_ready` is low, the block holds SCL low after the ninth clock. This is how back-pressure reaches the bus master. A stop releases both lines and clears the selected state.

Top module: `i2c_addr_slave`

## Requirements
- R1: A start is SDA falling while SCL is high, and it begins address reception. A stop is SDA rising while SCL is high. A stop releases both lines (`scl_oe`=0, `sda_oe`=0) and clears `selected`.
- R2: When bits 7..1 of the first byte after a start equal `own_addr`, the block pulls SDA low during the ninth clock without any software action.
- R3: On an address match, `addr_irq` pulses for one cycle after the ninth clock falls. At the same time SCL is held low (`scl_oe`=1).
- R4: On an address mismatch there is no ACK, no `addr_irq` and no clock stretch. Later bytes are not acknowledged and are not delivered until the next start.
- R5: In a read (bit 0 of the address byte = 1), SCL is held low with `tx_ready`=1 until `tx_valid`. The handshaken byte is then driven MSB first, and `sda_oe` changes only while SCL is low.
- R6: After a transmitted byte, a master ACK (SDA low on the ninth clock) makes the block stretch again for the next transmit byte. A NACK releases SDA until the next start, so further clocks read 0xFF and `selected` drops.
- R7: In a write (bit 0 = 0), every data byte is acknowledged and presented on `rx_data` with `rx_valid`=1. Both hold unchanged until `rx_ready`=1, and each byte is delivered once and in bus order.
- R8: In a write, after the ninth clock of the address or of a data byte, SCL is held low until no received byte is pending and `rx_ready`=1. No received byte ever overwrites a pending one.
- R9: `selected` is 1 from the address-match interrupt until a stop, a start or a read NACK. `read_mode` is 1 while the block is selected for a read.
- R10: A repeated start at any point restarts address reception. An address that was ignored can be followed by a matching one in the same bus ownership.
- R11: After reset both line drivers are off, and `tx_ready`, `rx_valid`, `addr_irq` and `selected` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_addr | input | 7 | Seven-bit address this target answers to |
| scl_i | input | 1 | Sensed SCL level |
| sda_i | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | 1 pulls SCL low (open drain) |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| tx_data | input | 8 | Byte to send in a read |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Block is stretching and will take a transmit byte |
| rx_data | output | 8 | Last byte received in a write |
| rx_valid | output | 1 | `rx_data` holds an unconsumed byte |
| rx_ready | input | 1 | Consumer accepts `rx_data` |
| addr_irq | output | 1 | One-cycle address-match interrupt |
| selected | output | 1 | Block is the addressed target |
| read_mode | output | 1 | Selected for a read transaction |

## Verification
The hardest situation to reach from the ports is a data-byte stretch in a write. The previous byte must still be pending on `rx_data` when the next ninth clock falls, and the master must keep honouring the held clock. The bench models a master that synchronises its clock to the bus. It drops `rx_ready` right after the address, so the first data byte stays pending. A delayed process then checks the pending byte and the held line, and only after that raises `rx_ready`. The cycles the master spends waiting on SCL are counted for each bit. In this way the stretch after the address, after a data byte and before each transmit byte is measured, and the absence of a stretch after a mismatch is checked too.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W - 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX_HOLD,
    ST_RX_BYTE,
    ST_RX_ACK,
    ST_TX_HOLD,
    ST_TX_REL,
    ST_TX_BYTE,
    ST_TX_ACK,
    ST_IGNORE
  } slv_state_e;
endpackage

// File: rtl/i2c_slv_sync.sv
module i2c_slv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int LANES   = 2;
  localparam int L_SCL   = 1;
  localparam int L_SDA   = 0;

  logic [LANES-1:0] line_in;
  logic [LANES-1:0] line_s;
  logic [LANES-1:0] line_d;

  assign line_in = {scl_i, sda_i};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], line_in[g]};
    end
    assign line_s[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_d <= '1;
    else        line_d <= line_s;
  end

  assign scl_s     = line_s[L_SCL];
  assign sda_s     = line_s[L_SDA];
  assign scl_rise  = line_s[L_SCL] & ~line_d[L_SCL];
  assign scl_fall  = ~line_s[L_SCL] & line_d[L_SCL];
  assign start_det = line_s[L_SCL] & line_d[L_SCL] & line_d[L_SDA] & ~line_s[L_SDA];
  assign stop_det  = line_s[L_SCL] & line_d[L_SCL] & ~line_d[L_SDA] & line_s[L_SDA];
endmodule

// File: rtl/i2c_slv_rxhold.sv
module i2c_slv_rxhold
  import i2c_slv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] din,
  input  logic              rx_ready,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else if (load) begin
      rx_valid <= 1'b1;
      rx_data  <= din;
    end else if (rx_valid && rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R7
  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !rx_valid); // R8
endmodule

// File: rtl/i2c_slv_ctrl.sv
module i2c_slv_ctrl
  import i2c_slv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic              rx_pending,
  input  logic              rx_ready,
  output logic              rx_load,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              addr_irq,
  output logic              selected,
  output logic              read_mode
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  slv_state_e        state;
  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  bitcnt;
  logic              rw_q;
  logic              sel_q;
  logic              mack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      shreg    <= '0;
      bitcnt   <= '0;
      rw_q     <= 1'b0;
      sel_q    <= 1'b0;
      mack     <= 1'b0;
      scl_oe   <= 1'b0;
      sda_oe   <= 1'b0;
      addr_irq <= 1'b0;
      rx_load  <= 1'b0;
      rx_byte  <= '0;
    end else begin
      addr_irq <= 1'b0;
      rx_load  <= 1'b0;
      if (start_det) begin
        state  <= ST_ADDR;
        bitcnt <= '0;
        scl_oe <= 1'b0;
        sda_oe <= 1'b0;
        sel_q  <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        scl_oe <= 1'b0;
        sda_oe <= 1'b0;
        sel_q  <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR: begin
            if (scl_rise) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == LAST_BIT) begin
              if (shreg[BYTE_W-1:1] == own_addr) begin
                sda_oe <= 1'b1;
                rw_q   <= shreg[0];
                state  <= ST_ADDR_ACK;
              end else begin
                state  <= ST_IGNORE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              sda_oe   <= 1'b0;
              scl_oe   <= 1'b1;
              addr_irq <= 1'b1;
              sel_q    <= 1'b1;
              bitcnt   <= '0;
              state    <= rw_q ? ST_TX_HOLD : ST_RX_HOLD;
            end
          end
          ST_RX_HOLD: begin
            if (!rx_pending && rx_ready) begin
              scl_oe <= 1'b0;
              bitcnt <= '0;
              state  <= ST_RX_BYTE;
            end
          end
          ST_RX_BYTE: begin
            if (scl_rise) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == LAST_BIT) begin
              rx_load <= 1'b1;
              rx_byte <= shreg;
              sda_oe  <= 1'b1;
              state   <= ST_RX_ACK;
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              scl_oe <= 1'b1;
              state  <= ST_RX_HOLD;
            end
          end
          ST_TX_HOLD: begin
            if (tx_valid) begin
              shreg  <= tx_data;
              sda_oe <= ~tx_data[BYTE_W-1];
              state  <= ST_TX_REL;
            end
          end
          ST_TX_REL: begin
            scl_oe <= 1'b0;
            bitcnt <= '0;
            state  <= ST_TX_BYTE;
          end
          ST_TX_BYTE: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall) begin
              if (bitcnt == LAST_BIT) begin
                sda_oe <= 1'b0;
                state  <= ST_TX_ACK;
              end else begin
                shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                sda_oe <= ~shreg[BYTE_W-2];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                scl_oe <= 1'b1;
                state  <= ST_TX_HOLD;
              end else begin
                sel_q  <= 1'b0;
                state  <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign tx_ready  = (state == ST_TX_HOLD);
  assign selected  = sel_q;
  assign read_mode = sel_q & rw_q;

  AST_SDA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s)); // R5
  AST_TXRDY_STRETCHED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> scl_oe); // R5
  AST_IRQ_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    addr_irq |-> (scl_oe && selected)); // R3
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_irq |=> !addr_irq); // R3
  AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE) |-> (!scl_oe && !sda_oe && !addr_irq && !rx_load)); // R4
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!scl_oe && !sda_oe && !selected)); // R1
endmodule

// File: rtl/i2c_addr_slave.sv
module i2c_addr_slave
  import i2c_slv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              addr_irq,
  output logic              selected,
  output logic              read_mode
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic rx_load;
  logic [BYTE_W-1:0] rx_byte;

  i2c_slv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_slv_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .own_addr   (own_addr),
    .scl_s      (scl_s),
    .sda_s      (sda_s),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .tx_data    (tx_data),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .rx_pending (rx_valid),
    .rx_ready   (rx_ready),
    .rx_load    (rx_load),
    .rx_byte    (rx_byte),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .addr_irq   (addr_irq),
    .selected   (selected),
    .read_mode  (read_mode)
  );

  i2c_slv_rxhold u_rxh (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (rx_load),
    .din      (rx_byte),
    .rx_ready (rx_ready),
    .rx_valid (rx_valid),
    .rx_data  (rx_data)
  );
endmodule

// File: tb/i2c_addr_slave_tb.sv
module i2c_addr_slave_tb;
  localparam int H = 24;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic scl, sda;
  logic scl_oe, sda_oe;
  logic [7:0] tx_data = '0;
  logic tx_valid = 1'b0;
  logic tx_ready;
  logic [7:0] rx_data;
  logic rx_valid;
  logic rx_rdy = 1'b0;
  logic addr_irq, selected, read_mode;

  int checks = 0, errors = 0, irq_cnt = 0, stretch_cyc = 0;
  bit done = 0;
  logic tx_hs = 0, rx_hs = 0;
  logic [7:0] rx_hs_data = '0;
  logic [7:0] exp_rx_q[$];
  logic [7:0] exp_rd_q[$];
  logic [7:0] tx_q[$];

  always #10 clk = ~clk;

  assign scl = m_scl & ~scl_oe;
  assign sda = m_sda & ~sda_oe;

  i2c_addr_slave u_dut (
    .clk(clk), .rst_n(rst_n), .own_addr(OWN), .scl_i(scl), .sda_i(sda),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_rdy),
    .addr_irq(addr_irq), .selected(selected), .read_mode(read_mode)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    tx_hs      <= tx_valid && tx_ready;
    rx_hs      <= rx_valid && rx_rdy;
    rx_hs_data <= rx_data;
    if (addr_irq) irq_cnt <= irq_cnt + 1;
  end

  // transmit feeder: offers the head of tx_q, pops after each handshake
  always @(negedge clk) begin
    if (tx_hs && tx_q.size() != 0) void'(tx_q.pop_front());
    tx_valid = (tx_q.size() != 0);
    if (tx_q.size() != 0) tx_data = tx_q[0];
  end

  // monitor: compares every accepted receive byte with the scoreboard (R7)
  always @(negedge clk) begin
    if (rx_hs) begin
      if (exp_rx_q.size() == 0) chk(1'b0, "R7 unexpected rx byte", rx_hs_data, 0);
      else begin
        logic [7:0] e;
        e = exp_rx_q.pop_front();
        chk(rx_hs_data == e, "R7 rx byte order", rx_hs_data, e);
      end
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic r);
    m_sda = b;
    wt(H);
    m_scl = 1'b1;
    @(negedge clk);
    while (scl == 1'b0) begin stretch_cyc++; @(negedge clk); end
    wt(H / 2);
    r = sda;
    wt(H / 2);
    m_scl = 1'b0;
    wt(4);
  endtask

  task automatic start_c();
    m_sda = 1'b1; m_scl = 1'b1; wt(H);
    m_sda = 1'b0; wt(H);
    m_scl = 1'b0; wt(4);
  endtask

  task automatic rstart_c();
    m_sda = 1'b1; wt(H);
    m_scl = 1'b1; @(negedge clk);
    while (scl == 1'b0) @(negedge clk);
    wt(H);
    m_sda = 1'b0; wt(H);
    m_scl = 1'b0; wt(4);
  endtask

  task automatic stop_c();
    m_sda = 1'b0; wt(H);
    m_scl = 1'b1; @(negedge clk);
    while (scl == 1'b0) @(negedge clk);
    wt(H);
    m_sda = 1'b1; wt(H);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
    clk_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic rd_byte(input logic give_ack, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, r); b[i] = r; end
    clk_bit(~give_ack, r);
  endtask

  // driver: pushes the expected receive item, then sends it
  task automatic drv_wr(input logic [7:0] b);
    logic ack;
    exp_rx_q.push_back(b);
    wr_byte(b, ack);
    chk(ack == 1'b1, "R7 data byte acked", ack, 1);
  endtask

  // master read: pops the expected transmit item and compares
  task automatic drv_rd(input logic give_ack, input string tag);
    logic [7:0] b, e;
    rd_byte(give_ack, b);
    e = exp_rd_q.pop_front();
    chk(b == e, tag, b, e);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] b;
    int irq0;
    wt(5);
    // R11 reset state
    chk(scl_oe == 0 && sda_oe == 0, "R11 lines released", {scl_oe, sda_oe}, 0);
    chk(tx_ready == 0 && rx_valid == 0 && addr_irq == 0 && selected == 0,
        "R11 outputs idle", {tx_ready, rx_valid, addr_irq, selected}, 0);
    rst_n = 1'b1;
    wt(5);

    // write with stretch after the address (rx_ready low)
    start_c();
    wr_byte({OWN, 1'b0}, ack);
    chk(ack == 1, "R2 address acked", ack, 1);
    fork begin wt(300); rx_rdy = 1'b1; end join_none
    stretch_cyc = 0;
    drv_wr(8'hA5);
    chk(stretch_cyc >= 200, "R8 stretch after address", stretch_cyc, 200);
    chk(irq_cnt == 1, "R3 one interrupt on match", irq_cnt, 1);
    chk(selected == 1 && read_mode == 0, "R9 selected for write", {selected, read_mode}, 2);
    drv_wr(8'h3C);
    stop_c();
    wt(10);
    chk(selected == 0 && scl_oe == 0 && sda_oe == 0, "R1 stop releases",
        {selected, scl_oe, sda_oe}, 0);

    // write with a pending byte: stretch after a data byte
    start_c();
    wr_byte({OWN, 1'b0}, ack);
    chk(ack == 1, "R2 address acked again", ack, 1);
    rx_rdy = 1'b0;
    drv_wr(8'h77);
    fork begin
      wt(200);
      chk(rx_valid == 1 && rx_data == 8'h77, "R7 pending byte held", {rx_valid, rx_data}, 9'h177);
      chk(scl_oe == 1, "R8 stretch while byte pending", scl_oe, 1);
      rx_rdy = 1'b1;
    end join_none
    stretch_cyc = 0;
    drv_wr(8'h08);
    chk(stretch_cyc >= 150, "R8 data-byte stretch length", stretch_cyc, 150);
    stop_c();

    // mismatch: silent, no stretch, bus ignored
    irq0 = irq_cnt;
    start_c();
    stretch_cyc = 0;
    wr_byte({7'h5B, 1'b1}, ack);
    chk(ack == 0, "R4 mismatch nacked", ack, 0);
    wr_byte(8'hC3, ack);
    chk(ack == 0, "R4 later byte ignored", ack, 0);
    chk(stretch_cyc == 0, "R4 no stretch on mismatch", stretch_cyc, 0);
    chk(irq_cnt == irq0 && selected == 0, "R4 no interrupt on mismatch", irq_cnt, irq0);
    stop_c();

    // read: stretch until transmit byte, ACK restretches, NACK releases
    start_c();
    wr_byte({OWN, 1'b1}, ack);
    chk(ack == 1, "R2 read address acked", ack, 1);
    exp_rd_q.push_back(8'h96);
    fork begin wt(200); tx_q.push_back(8'h96); end join_none
    stretch_cyc = 0;
    drv_rd(1'b1, "R5 first read byte");
    chk(stretch_cyc >= 150, "R5 stretch until tx byte", stretch_cyc, 150);
    chk(read_mode == 1, "R9 read mode", read_mode, 1);
    exp_rd_q.push_back(8'h41);
    fork begin wt(200); tx_q.push_back(8'h41); end join_none
    stretch_cyc = 0;
    drv_rd(1'b0, "R6 second read byte");
    chk(stretch_cyc >= 150, "R6 restretch after master ack", stretch_cyc, 150);
    rd_byte(1'b0, b);
    chk(b == 8'hFF, "R6 released after nack", b, 8'hFF);
    chk(selected == 0, "R6 deselected after nack", selected, 0);
    stop_c();

    // repeated start after an ignored address
    irq0 = irq_cnt;
    start_c();
    wr_byte({7'h21, 1'b0}, ack);
    chk(ack == 0, "R10 first address ignored", ack, 0);
    rstart_c();
    wr_byte({OWN, 1'b0}, ack);
    chk(ack == 1, "R10 match after repeated start", ack, 1);
    drv_wr(8'h5E);
    chk(irq_cnt == irq0 + 1, "R10 interrupt after repeated start", irq_cnt, irq0 + 1);
    stop_c();

    wt(50);
    chk(exp_rx_q.size() == 0, "R7 all rx bytes delivered", exp_rx_q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule